// File: doc/BRIEF.md
# Grouped Double-Buffered Compare Latches

This block is the shadow stage of a seven-channel compare timer. Software writes a compare value into a channel's holding register, but the comparator never looks at that register. It compares the running count against a separate active latch. The holding register is copied into the active latch only when a load event occurs. Each channel has a two-bit load policy that selects the event: the write itself, the count reaching zero, the count reaching zero or the period, or the count reaching the channel's own latch value.

A group selector lets several channels share the load event of one leader channel. All members of a group then refresh in the same clock, so related PWM edges move together. The block also holds the shared timer counter. The counter's length is 8, 10, 12 or 16 bits, and it runs in one of three counting modes or is stopped. Channel 0's active latch is the period for up mode and up/down mode. Each channel raises a one-cycle equality strobe when the advancing count matches its latch.

Top module: `cmp_shadow_latch`

## Requirements
- R1: `cnt_len` selects the counter maximum: 0 gives 0xFFFF, 1 gives 0x0FFF, 2 gives 0x03FF and 3 gives 0x00FF. In continuous mode (`run_mode`=2), an advance from the maximum goes to 0. The count is always masked to the selected length.
- R2: In up mode (`run_mode`=1), an advance from a count at or above the period (channel 0 latch, masked) goes to 0. In up/down mode (`run_mode`=3), the count climbs to the period, descends to 0, then climbs again.
- R3: In stop mode (`run_mode`=0), or while `tick` is low, the count holds.
- R4: A write (`wr_en`, `wr_ch` 0..6) stores `wr_data` in that channel's holding register. A write with `wr_ch`=7 has no effect. Load policy 0 copies the written value into the latch in the same edge.
- R5: Load policy 1 loads the latch on an advance cycle in which the count is 0.
- R6: Load policy 2 loads on an advance at count 0. In up/down mode it also loads at a count equal to the period.
- R7: Load policy 3 loads on an advance in which the count equals that channel's current latch value (masked).
- R8: Group code 0 keeps every channel independent. Code 1 places channels 2, 4 and 6 under leaders 1, 3 and 5. Code 2 places 2 and 3 under leader 1, and 5 and 6 under leader 4. Code 3 places all seven channels under channel 1. Channel 0 leads itself in codes 0 to 2. A member's own load policy is ignored.
- R9: A load takes effect at the clock edge that ends the event cycle. The source is the holding register, or `wr_data` when that channel is being written in the same cycle. Equality in the event cycle uses the old latch value.
- R10: `equ[i]` is high exactly in the cycles with `tick` high, a non-stop mode, and the count equal to channel i's latch masked to the selected length.
- R11: After reset, the count, all holding registers, all latches and the direction state are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Counter advance enable |
| run_mode | input | 2 | 0 stop, 1 up, 2 continuous, 3 up/down |
| cnt_len | input | 2 | Counter length code |
| grp_sel | input | 2 | Channel grouping code |
| ld_ctl | input | 14 | Load policy, two bits per channel, channel i at [2i+1:2i] |
| wr_en | input | 1 | Holding register write strobe |
| wr_ch | input | 3 | Channel written |
| wr_data | input | 16 | Value written |
| count | output | 16 | Current count |
| equ | output | 7 | Per-channel equality strobe |
| active | output | 112 | Active latches, channel i at [16i+15:16i] |

## Verification
Two things can fall in the same cycle: a latch transfer and a compare against that same channel. The other case is a write landing in the cycle of a load event. Both are provoked by a directed run: policy 3 makes a channel reload exactly on its own match, and random writes keep hitting event cycles in every phase. The bench judges them by checking that the strobe reflects the old latch, and that the new latch holds the just-written data one edge later. It compares every cycle against a bench model built from the rules above.

// File: rtl/cmp_shadow_latch.sv
module cmp_shadow_latch #(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [1:0]        run_mode,
  input  logic [1:0]        cnt_len,
  input  logic [1:0]        grp_sel,
  input  logic [13:0]       ld_ctl,
  input  logic              wr_en,
  input  logic [2:0]        wr_ch,
  input  logic [CW-1:0]     wr_data,
  output logic [CW-1:0]     count,
  output logic [6:0]        equ,
  output logic [7*CW-1:0]   active
);
  localparam int NCH = 7;
  localparam logic [1:0] M_STOP = 2'd0, M_UP = 2'd1, M_CONT = 2'd2, M_UPDN = 2'd3;
  localparam logic [CW-1:0] ONES = {CW{1'b1}};

  logic [CW-1:0] cnt_q, cnt_d, top_val, per;
  logic          dn_q, dn_d, adv;
  logic [CW-1:0] reg_q [NCH];
  logic [CW-1:0] lat_q [NCH];
  logic [NCH-1:0] wr_hit, own_ev, ld_ev;

  function automatic int lead_of(input logic [1:0] g, input int i);
    case (g)
      2'd1:    return (i == 0) ? 0 : ((i % 2 == 1) ? i : i - 1);
      2'd2:    return (i == 0) ? 0 : ((i <= 3) ? 1 : 4);
      2'd3:    return 1;
      default: return i;
    endcase
  endfunction

  always_comb begin
    case (cnt_len)
      2'd1:    top_val = ONES >> (CW - 12);
      2'd2:    top_val = ONES >> (CW - 10);
      2'd3:    top_val = ONES >> (CW - 8);
      default: top_val = ONES;
    endcase
  end

  assign per = lat_q[0] & top_val;
  assign adv = tick && (run_mode != M_STOP);

  always_comb begin
    cnt_d = cnt_q;
    dn_d  = 1'b0;
    if (adv) begin
      case (run_mode)
        M_UP:   cnt_d = (cnt_q >= per) ? '0 : cnt_q + 1'b1;
        M_CONT: cnt_d = (cnt_q >= top_val) ? '0 : cnt_q + 1'b1;
        M_UPDN: begin
          if (!dn_q) begin
            if (cnt_q >= per) begin
              dn_d  = (per != '0);
              cnt_d = (per == '0) ? '0 : cnt_q - 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end else if (cnt_q == '0) begin
            cnt_d = (per == '0) ? '0 : CW'(1);
          end else begin
            dn_d  = 1'b1;
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: cnt_d = cnt_q;
      endcase
    end else begin
      dn_d = dn_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d & top_val;
      dn_q  <= dn_d;
    end
  end

  always_comb begin
    for (int j = 0; j < NCH; j++) begin
      wr_hit[j] = wr_en && (wr_ch == 3'(j));
      case (ld_ctl[2*j +: 2])
        2'd0:    own_ev[j] = wr_hit[j];
        2'd1:    own_ev[j] = adv && (cnt_q == '0);
        2'd2:    own_ev[j] = adv && ((cnt_q == '0) || ((run_mode == M_UPDN) && (cnt_q == per)));
        default: own_ev[j] = adv && (cnt_q == (lat_q[j] & top_val));
      endcase
    end
    for (int i = 0; i < NCH; i++) ld_ev[i] = own_ev[lead_of(grp_sel, i)];
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_q[g] <= '0;
        lat_q[g] <= '0;
      end else begin
        if (wr_hit[g]) reg_q[g] <= wr_data;
        if (ld_ev[g])  lat_q[g] <= wr_hit[g] ? wr_data : reg_q[g];
      end
    end
    assign equ[g] = adv && (cnt_q == (lat_q[g] & top_val));
    assign active[g*CW +: CW] = lat_q[g];

    assert_latch_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_ev[g] |=> $stable(lat_q[g]));
    assert_write_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit[g] && grp_sel == 2'd0 && ld_ctl[2*g +: 2] == 2'd0) |=> lat_q[g] == $past(wr_data));
  end

  assign count = cnt_q;

  assert_count_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q & ~$past(top_val)) == '0);
  assert_cont_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && run_mode == M_CONT && cnt_q >= top_val) |=> cnt_q == '0);
  assert_up_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && run_mode == M_UP && cnt_q >= per) |=> cnt_q == '0);
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && (cnt_q & top_val) == cnt_q) |=> $stable(cnt_q));
  assert_equ_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |-> equ == '0);
endmodule

// File: tb/cmp_shadow_latch_tb_top.sv
`timescale 1ns/1ps
module cmp_shadow_latch_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [1:0] run_mode = 2'd0, cnt_len = 2'd0, grp_sel = 2'd0;
  logic [13:0] ld_ctl = '0;
  logic [2:0] wr_ch = 3'd7;
  logic [15:0] wr_data = '0, count;
  logic [6:0] equ;
  logic [111:0] active;

  int checks = 0, fails = 0;
  logic [15:0] m_cnt, m_reg [7], m_lat [7];
  logic m_dn;

  cmp_shadow_latch dut_i (.clk(clk), .rst_n(rst_n), .tick(tick), .run_mode(run_mode),
    .cnt_len(cnt_len), .grp_sel(grp_sel), .ld_ctl(ld_ctl), .wr_en(wr_en), .wr_ch(wr_ch),
    .wr_data(wr_data), .count(count), .equ(equ), .active(active));

  always #10 clk = ~clk;

  function automatic logic [15:0] f_top(input logic [1:0] l);
    case (l) 2'd1: return 16'h0FFF; 2'd2: return 16'h03FF; 2'd3: return 16'h00FF; default: return 16'hFFFF; endcase
  endfunction

  function automatic int f_lead(input logic [1:0] g, input int i);
    if (g == 2'd3) return 1;
    if (i == 0 || g == 2'd0) return i;
    if (g == 2'd1) return (i % 2 == 1) ? i : i - 1;
    return (i <= 3) ? 1 : 4;
  endfunction

  function automatic logic [6:0] f_equ();
    logic [6:0] e;
    for (int i = 0; i < 7; i++)
      e[i] = tick && run_mode != 2'd0 && m_cnt == (m_lat[i] & f_top(cnt_len));
    return e;
  endfunction

  task automatic model_step();
    logic [15:0] top, per, nc;
    logic adv, nd, hit;
    logic [6:0] own;
    logic [15:0] nl [7];
    top = f_top(cnt_len);
    per = m_lat[0] & top;
    adv = tick && run_mode != 2'd0;
    for (int j = 0; j < 7; j++) begin
      hit = wr_en && wr_ch == 3'(j);
      case (ld_ctl[2*j +: 2])
        2'd0: own[j] = hit;
        2'd1: own[j] = adv && m_cnt == 0;
        2'd2: own[j] = adv && (m_cnt == 0 || (run_mode == 2'd3 && m_cnt == per));
        default: own[j] = adv && m_cnt == (m_lat[j] & top);
      endcase
    end
    nc = m_cnt; nd = adv ? 1'b0 : m_dn;
    if (adv) begin
      if (run_mode == 2'd1) nc = (m_cnt >= per) ? 16'd0 : m_cnt + 16'd1;
      else if (run_mode == 2'd2) nc = (m_cnt >= top) ? 16'd0 : m_cnt + 16'd1;
      else if (!m_dn) begin
        if (m_cnt >= per) begin nd = per != 0; nc = (per == 0) ? 16'd0 : m_cnt - 16'd1; end
        else nc = m_cnt + 16'd1;
      end else if (m_cnt == 0) nc = (per == 0) ? 16'd0 : 16'd1;
      else begin nd = 1'b1; nc = m_cnt - 16'd1; end
    end
    for (int i = 0; i < 7; i++) begin
      hit = wr_en && wr_ch == 3'(i);
      nl[i] = own[f_lead(grp_sel, i)] ? (hit ? wr_data : m_reg[i]) : m_lat[i];
      if (hit) m_reg[i] = wr_data;
    end
    for (int i = 0; i < 7; i++) m_lat[i] = nl[i];
    m_cnt = nc & top; m_dn = nd;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_dn = 0;
      for (int i = 0; i < 7; i++) begin m_reg[i] = 0; m_lat[i] = 0; end
    end else model_step();
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input string req);
    @(negedge clk);
    chk(count == m_cnt, req, count, m_cnt);
    chk(equ == f_equ(), {req, " equ R10"}, {9'd0, equ}, {9'd0, f_equ()});
    for (int i = 0; i < 7; i++) chk(active[16*i +: 16] == m_lat[i], {req, " latch"}, active[16*i +: 16], m_lat[i]);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; tick = 0; wr_en = 0; run_mode = 0; grp_sel = 0; ld_ctl = 0; cnt_len = 0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input int ch, input logic [15:0] d);
    wr_en = 1'b1; wr_ch = 3'(ch); wr_data = d;
  endtask

  task automatic rnd_phase(input string req, input int n, input int md, input int ln, input int gp, input int lc, input bit rnd_cfg);
    run_mode = 2'(md); cnt_len = 2'(ln); grp_sel = 2'(gp);
    for (int j = 0; j < 7; j++) ld_ctl[2*j +: 2] = (lc < 0) ? 2'($urandom % 4) : 2'(lc);
    for (int k = 0; k < n; k++) begin
      cyc(req);
      if (rnd_cfg && k % 50 == 0) begin
        run_mode = 2'($urandom % 4); cnt_len = 2'($urandom % 4); grp_sel = 2'($urandom % 4);
        ld_ctl = 14'($urandom);
      end
      tick = ($urandom % 8) != 0;
      wr_en = ($urandom % 4) == 0;
      wr_ch = 3'($urandom % 8);
      wr_data = (($urandom % 16) == 0) ? 16'($urandom) : 16'($urandom % 40);
    end
    wr_en = 0; tick = 0;
  endtask

  initial begin
    #(20ns * 190000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int guard;
    logic [15:0] exp_up [4];
    void'($urandom(32'd4242));
    exp_up[0] = 16'd1; exp_up[1] = 16'd2; exp_up[2] = 16'd3; exp_up[3] = 16'd0;
    do_reset();
    cyc("R11");
    chk(count == 0, "R11 count", count, 0);
    for (int i = 0; i < 7; i++) chk(active[16*i +: 16] == 0, "R11 latch", active[16*i +: 16], 0);

    wr(3, 16'h1234); cyc("R4"); wr_en = 0;
    cyc("R4");
    chk(active[48 +: 16] == 16'h1234, "R4 immediate load", active[48 +: 16], 16'h1234);
    wr(7, 16'hBEEF); cyc("R4"); wr_en = 0; cyc("R4");
    chk(active[48 +: 16] == 16'h1234, "R4 channel 7 ignored", active[48 +: 16], 16'h1234);

    do_reset();
    wr(0, 16'd3); cyc("R2"); wr_en = 0; run_mode = 2'd1; tick = 1;
    for (int k = 0; k < 4; k++) begin
      cyc("R2");
      chk(count == exp_up[k], "R2 up wrap", count, exp_up[k]);
    end
    run_mode = 2'd3;
    for (int k = 0; k < 12; k++) cyc("R2");
    run_mode = 2'd0;
    cyc("R3");
    begin
      logic [15:0] held;
      held = count;
      for (int k = 0; k < 5; k++) begin
        cyc("R3");
        chk(count == held, "R3 stop hold", count, held);
      end
    end

    do_reset();
    cnt_len = 2'd3; run_mode = 2'd2; tick = 1;
    guard = 0;
    do begin cyc("R1"); guard++; end while (count != 16'h00FF && guard < 400);
    cyc("R1");
    chk(count == 16'h0000, "R1 8-bit wrap", count, 16'h0000);

    do_reset();
    grp_sel = 2'd3; ld_ctl = 14'b00_00_00_00_00_01_00;
    wr(5, 16'h0077); cyc("R8"); wr_en = 0;
    cyc("R8");
    chk(active[80 +: 16] == 16'h0000, "R8 member policy ignored", active[80 +: 16], 0);
    run_mode = 2'd2; tick = 1; cyc("R8"); tick = 0;
    cyc("R8");
    chk(active[80 +: 16] == 16'h0077, "R8 group load", active[80 +: 16], 16'h0077);

    do_reset();
    wr(2, 16'd5); cyc("R9"); wr(2, 16'd9); ld_ctl[5:4] = 2'd3; cyc("R9");
    wr_en = 0; run_mode = 2'd2; tick = 1;
    guard = 0;
    do begin cyc("R9"); guard++; end while (count != 16'd5 && guard < 20);
    chk(equ[2] == 1'b1, "R9 old value compare", {15'd0, equ[2]}, 1);
    chk(active[32 +: 16] == 16'd5, "R9 old latch in event cycle", active[32 +: 16], 5);
    cyc("R9");
    chk(active[32 +: 16] == 16'd9, "R9 transfer next edge", active[32 +: 16], 9);
    chk(equ[2] == 1'b0, "R9 no match at 6", {15'd0, equ[2]}, 0);

    do_reset(); rnd_phase("R5", 700, 2, 3, 0, 1, 0);
    do_reset(); rnd_phase("R6", 500, 3, 0, 0, 2, 0);
    do_reset(); rnd_phase("R7", 500, 1, 1, 0, 3, 0);
    do_reset(); rnd_phase("R8", 500, 3, 2, 1, -1, 0);
    do_reset(); rnd_phase("R8", 500, 1, 0, 2, -1, 0);
    do_reset(); rnd_phase("R10", 2000, 2, 3, 3, -1, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule